// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Filter

This block is an 8-tap, linear-phase FIR filter built for minimum area. Its coefficients mirror around the centre, so only four of them are stored. A new signed sample arrives on a parallel bus together with a strobe. The filter then spends one clock per bit of the sample, plus one more clock, to produce a single exact result. No multipliers are used. Each clock, the four mirrored tap pairs are added one bit at a time by serial adders. The four resulting bits index one shared 16-entry table, which holds every possible sum of the coefficients. A right-shifting accumulator combines the table outputs from all the bit clocks, and on the final clock it subtracts, because that clock carries the sign bit.

A small sequencer issues the load, carry-clear, accumulator-clear, add/subtract and latch strobes. Each delay-line stage rotates its bits as they are read out, so the stored history is intact when the next sample arrives. Bits that fall off the low end of the accumulator are kept, so the latched result is exact at full width. The block fits where the sample rate is at most one sample per (sample width + 1) clocks.

Top module: `fir_da_serial`

## Requirements
- R1: When a sample is accepted, it becomes tap 0 and every older tap moves one stage deeper. The eight stages then hold x0 (newest) to x7. The result is the exact signed value sum over p = 0..3 of h_p * (x_p + x_(7-p)). Coefficient h_p sits at bits [8p+7:8p] of `COEFS`. The default coefficients are h0=-3, h1=10, h2=37, h3=90.
- R2: Samples are two's complement, 7 bits wide. The extreme values -64 and +63 give exact results, including the largest-magnitude output.
- R3: `out_valid` is high in the cycle after the 8th rising edge that follows the edge which captured an accepted strobe.
- R4: A strobe that arrives while a computation is in progress, other than on its final bit clock, is ignored. The delay line is left unchanged, and no extra result is produced.
- R5: A strobe on the final bit clock is accepted. This gives one result every 8 clocks when the strobe is held on the right cycles.
- R6: `out_y` holds its last latched value between valid pulses.
- R7: `out_valid` lasts exactly one clock per result.
- R8: The carry flip-flops of the serial pair adders are zero on the first bit clock of every sample. A carry left over from the previous sample does not affect the next result.
- R9: On the sign-bit clock, the accumulator subtracts the table output instead of adding it. As a result, negative pair sums give correctly signed results.
- R10: Reading a stage out bit by bit leaves its stored value intact. Older samples therefore contribute correctly to every later result.
- R11: Synchronous active-high reset clears the delay line to zero, `out_y` to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New-sample strobe |
| in_sample | input | 7 | Signed input sample |
| out_valid | output | 1 | One-clock pulse when a result is latched |
| out_y | output | 18 | Signed filter result, held between pulses |

## Verification
Two events can fall in the same clock. On the final bit clock, the sign-bit subtraction and result latch of one sample can coincide with the load and carry clear of the next. The bench provokes this by sending strobes exactly 8 clocks apart, and also by holding the strobe high every clock. A reference model computes the expected result of each accepted sample from its own sample history. The model decides acceptance from the stated timing rule and compares `out_valid` and `out_y` on every clock, so a result corrupted by the overlap, or a strobe wrongly accepted or dropped, shows up as a mismatch.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    localparam int DEF_SAMPLE_W = 7;
    localparam int DEF_COEF_W   = 8;
    localparam int DEF_PAIRS    = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    // Sequencing strobes issued by the controller each clock
    typedef struct packed {
        logic load;       // capture a new sample into the delay line
        logic carry_clr;  // zero the serial-adder carries
        logic acc_clr;    // treat previous accumulator value as zero
        logic run;        // a bit clock is in progress
        logic sub;        // sign-bit clock: subtract table output
        logic latch;      // capture the final result
    } ctl_strobes_t;

endpackage

// File: rtl/fir_da_ctrl.sv
module fir_da_ctrl
    import fir_da_pkg::*;
#(
    parameter int SW = DEF_SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    output ctl_strobes_t stb
);
    localparam int CNT_W = $clog2(SW + 1);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_bit;

    assign last_bit = (state_q == ST_RUN) && (cnt_q == CNT_W'(SW));

    always_comb begin
        stb.load      = strobe && ((state_q == ST_IDLE) || last_bit);
        stb.carry_clr = stb.load;
        stb.run       = (state_q == ST_RUN);
        stb.acc_clr   = (state_q == ST_RUN) && (cnt_q == '0);
        stb.sub       = last_bit;
        stb.latch     = last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (stb.load) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else if (last_bit) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (state_q == ST_RUN) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fir_da_taps.sv
module fir_da_taps
    import fir_da_pkg::*;
#(
    parameter int SW    = DEF_SAMPLE_W,
    parameter int PAIRS = DEF_PAIRS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    sample,
    input  ctl_strobes_t     stb,
    output logic [PAIRS-1:0] sum_bits,
    output logic [PAIRS-1:0] carry_q
);
    localparam int TAPS = 2 * PAIRS;

    logic [TAPS-1:0][SW-1:0] line_q;
    logic [TAPS-1:0]         ser;

    // Delay line: shift on load, rotate right on each data-bit clock
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (stb.load) begin
            line_q[0] <= sample;
            for (int t = 1; t < TAPS; t++) line_q[t] <= line_q[t-1];
        end else if (stb.run && !stb.sub) begin
            for (int t = 0; t < TAPS; t++) line_q[t] <= {line_q[t][0], line_q[t][SW-1:1]};
        end
    end

    // Sign-bit clock repeats the stored MSB (sign extension)
    always_comb begin
        for (int t = 0; t < TAPS; t++)
            ser[t] = stb.sub ? line_q[t][SW-1] : line_q[t][0];
    end

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            logic a_bit, b_bit;
            assign a_bit       = ser[p];
            assign b_bit       = ser[TAPS-1-p];
            assign sum_bits[p] = a_bit ^ b_bit ^ carry_q[p];

            always_ff @(posedge clk) begin
                if (rst || stb.carry_clr)
                    carry_q[p] <= 1'b0;
                else if (stb.run)
                    carry_q[p] <= (a_bit & b_bit) | (carry_q[p] & (a_bit ^ b_bit));
            end
        end
    endgenerate

endmodule

// File: rtl/fir_da_accum.sv
module fir_da_accum
    import fir_da_pkg::*;
#(
    parameter int                    SW    = DEF_SAMPLE_W,
    parameter int                    CW    = DEF_COEF_W,
    parameter int                    PAIRS = DEF_PAIRS,
    parameter logic [PAIRS*CW-1:0]   COEFS = 32'h5A250AFD,
    parameter int                    RW    = CW + $clog2(PAIRS) + SW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PAIRS-1:0]     addr,
    input  ctl_strobes_t         stb,
    output logic                 res_valid,
    output logic signed [RW-1:0] res_y
);
    localparam int TW = CW + $clog2(PAIRS);
    localparam int AW = RW - SW;

    // Coefficient-sum table entry, folded to constant logic
    function automatic logic signed [TW-1:0] tbl_entry(input logic [PAIRS-1:0] a);
        logic signed [TW-1:0] s;
        s = '0;
        for (int p = 0; p < PAIRS; p++)
            if (a[p]) s = s + TW'($signed(COEFS[p*CW +: CW]));
        return s;
    endfunction

    logic signed [TW-1:0] t_val;
    logic signed [AW-1:0] t_ext, base, shifted, nxt, acc_q;
    logic [SW-1:0]        ext_q, ext_nxt;

    assign t_val   = tbl_entry(addr);
    assign t_ext   = AW'(t_val);
    assign base    = stb.acc_clr ? '0 : acc_q;
    assign shifted = base >>> 1;
    assign nxt     = stb.sub ? (shifted - t_ext) : (shifted + t_ext);
    assign ext_nxt = {base[0], ext_q[SW-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            ext_q     <= '0;
            res_y     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= stb.latch;
            if (stb.run) begin
                acc_q <= nxt;
                ext_q <= ext_nxt;
            end
            if (stb.latch) res_y <= {nxt, ext_nxt};
        end
    end

endmodule

// File: rtl/fir_da_serial.sv
module fir_da_serial
    import fir_da_pkg::*;
#(
    parameter int                  SAMPLE_W = DEF_SAMPLE_W,
    parameter int                  COEF_W   = DEF_COEF_W,
    parameter int                  PAIRS    = DEF_PAIRS,
    parameter logic [PAIRS*COEF_W-1:0] COEFS = 32'h5A250AFD
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [SAMPLE_W-1:0]   in_sample,
    output logic                  out_valid,
    output logic signed [COEF_W+$clog2(PAIRS)+SAMPLE_W:0] out_y
);
    localparam int RW = COEF_W + $clog2(PAIRS) + SAMPLE_W + 1;

    ctl_strobes_t     ctl_stb;
    logic [PAIRS-1:0] pair_bits;
    logic [PAIRS-1:0] carry_q;

    fir_da_ctrl #(.SW(SAMPLE_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .strobe (in_valid),
        .stb    (ctl_stb)
    );

    fir_da_taps #(.SW(SAMPLE_W), .PAIRS(PAIRS)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .sample   (in_sample),
        .stb      (ctl_stb),
        .sum_bits (pair_bits),
        .carry_q  (carry_q)
    );

    fir_da_accum #(
        .SW(SAMPLE_W), .CW(COEF_W), .PAIRS(PAIRS), .COEFS(COEFS), .RW(RW)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .addr      (pair_bits),
        .stb       (ctl_stb),
        .res_valid (out_valid),
        .res_y     (out_y)
    );

endmodule

// File: rtl/fir_da_serial_chk.sv
module fir_da_serial_chk
    import fir_da_pkg::*;
#(
    parameter int SW    = DEF_SAMPLE_W,
    parameter int PAIRS = DEF_PAIRS,
    parameter int RW    = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [RW-1:0]    out_y,
    input ctl_strobes_t     stb,
    input logic [PAIRS-1:0] carry
);
    localparam int AGE_MAX = SW + 2;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);

    // Clocks since the last accepted load, saturating
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                          age_q <= AGE_W'(AGE_MAX);
        else if (stb.load)                age_q <= '0;
        else if (age_q != AGE_W'(AGE_MAX)) age_q <= age_q + 1'b1;
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_y));

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(age_q) == AGE_W'(SW)));

    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        stb.load |-> (in_valid && (age_q >= AGE_W'(SW))));

    assert_carry_clear_R8: assert property (@(posedge clk) disable iff (rst)
        stb.load |=> (carry == '0));

    assert_sign_subtract_R9: assert property (@(posedge clk) disable iff (rst)
        stb.sub |-> (age_q == AGE_W'(SW)));

endmodule

bind fir_da_serial fir_da_serial_chk #(
    .SW(SAMPLE_W), .PAIRS(PAIRS), .RW(COEF_W + $clog2(PAIRS) + SAMPLE_W + 1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_y     (out_y),
    .stb       (ctl_stb),
    .carry     (carry_q)
);

// File: tb/tb_fir_da_serial.sv
`timescale 1ns/1ps
module tb_fir_da_serial;
    localparam int SW = 7;
    localparam int RW = 18;
    localparam int H0 = -3, H1 = 10, H2 = 37, H3 = 90;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic          out_valid;
    logic [RW-1:0] out_y;

    fir_da_serial #(.SAMPLE_W(SW), .COEF_W(8), .PAIRS(4), .COEFS(32'h5A250AFD)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_y(out_y)
    );

    always #10 clk = ~clk;

    int    errs = 0, checks = 0, n = 0, last_acc = -1000, exp_y = 0;
    int    hist [8];
    int    due_q[$], val_q[$];
    string tag = "R11";
    bit [31:0] lfsr = 32'h1234_5679;

    function automatic int rnd7();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return int'(lfsr[6:0]) - 64;
    endfunction

    // One clock: compare at the falling edge, then drive for the next rise
    task automatic cyc(input bit s, input int x);
        bit exp_v;
        int got;
        @(negedge clk);
        n++;
        exp_v = 1'b0;
        if (due_q.size() > 0 && due_q[0] == n) begin
            exp_v = 1'b1;
            exp_y = val_q[0];
            void'(due_q.pop_front());
            void'(val_q.pop_front());
        end
        checks++;
        if (out_valid !== exp_v) begin
            errs++;
            $display("FAIL R3 R7 %s: out_valid=%0b expected %0b at cycle %0d", tag, out_valid, exp_v, n);
        end
        got = $signed(out_y);
        checks++;
        if (got !== exp_y) begin
            errs++;
            $display("FAIL R1 R6 %s: out_y=%0d expected %0d at cycle %0d", tag, got, exp_y, n);
        end
        in_valid  = s;
        in_sample = SW'(x);
        if (s && !rst && (n - last_acc >= SW + 1)) begin
            int y;
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = x;
            y = H0 * (hist[0] + hist[7]) + H1 * (hist[1] + hist[6])
              + H2 * (hist[2] + hist[5]) + H3 * (hist[3] + hist[4]);
            due_q.push_back(n + SW + 2);
            val_q.push_back(y);
            last_acc = n;
        end
    endtask

    task automatic send(input int x, input int gap);
        cyc(1'b1, x);
        for (int g = 1; g < gap; g++) cyc(1'b0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) hist[k] = 0;
        // R11: reset state
        tag = "R11";
        for (int i = 0; i < 4; i++) cyc(1'b0, 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1'b0, 0);

        // R10: impulse response walks through all taps
        tag = "R10";
        send(1, 8);
        for (int i = 0; i < 8; i++) send(0, 8);

        // R5: back-to-back samples on the final bit clock
        tag = "R5";
        for (int i = 0; i < 20; i++) send(rnd7(), 8);

        // R6: idle gaps, result must hold
        tag = "R6";
        for (int i = 0; i < 6; i++) send(rnd7(), 15);

        // R2: extreme values
        tag = "R2";
        for (int i = 0; i < 9; i++) send(-64, 9);
        for (int i = 0; i < 9; i++) send(63, 9);

        // R9: alternating signs exercise the sign-bit subtraction
        tag = "R9";
        for (int i = 0; i < 12; i++) send((i % 2) ? 63 : -64, 8);

        // R8: negative sums leave carries set at the end of a sample
        tag = "R8";
        for (int i = 0; i < 9; i++) send(-1, 8);
        for (int i = 0; i < 6; i++) send(i + 1, 8);

        // R4: strobe held every clock; only final-bit strobes are taken
        tag = "R4";
        for (int i = 0; i < 64; i++) cyc(1'b1, rnd7());
        for (int i = 0; i < 12; i++) cyc(1'b0, 0);

        // R1: mixed random traffic and spacing
        tag = "R1";
        for (int i = 0; i < 30; i++) send(rnd7(), 8 + (i % 5));
        for (int i = 0; i < 14; i++) cyc(1'b0, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule